// File: doc/BRIEF.md
# Dual-Channel Serial DAC Input Front End

This block is the digital side of a two-channel DAC. A host sends 16-bit words over a three-wire serial port. An active-low frame line opens each word, and data is taken on falling serial-clock edges. Each complete word carries a channel-select bit and a 12-bit code. The code goes into that channel's input register. The input registers reach the DAC core outputs in one of two ways. A falling edge on the load line copies both at the same time. If the load line is held low, both outputs update as soon as a word completes.

All serial and control pins are asynchronous to the fast system clock. Each one passes through a two-flop synchronizer, and its edges are detected in the system-clock domain. A clear line empties every register. A static format pin selects straight binary or twos-complement input codes. In twos-complement mode the code MSB is inverted on the way out, so the core always receives straight binary.

The receiver is a three-state machine:
- `RX_IDLE` waits for the frame line to go low, then moves to `RX_SHIFT` with the bit counter at zero.
- `RX_SHIFT` takes one bit per falling serial edge. If the frame line returns high, it aborts back to `RX_IDLE`. On the 16th edge it completes the word and moves to `RX_FULL`.
- `RX_FULL` ignores further clock edges. It returns to `RX_IDLE` once the frame line is high.

Top module: `dac2_serial_front`

## Requirements
- R1: During and right after reset, both register stages hold zero. Each output reads 0x000 with `twos_i`=0 and 0x800 with `twos_i`=1.
- R2: Word bits travel MSB first. Bit 13 selects the channel (0 = A on `code_a_o`, 1 = B on `code_b_o`). Bits 11..0 are the code. Bits 15, 14 and 12 have no effect.
- R3: While `load_n_i` stays high, a completed word changes only an input register. Both outputs keep their values.
- R4: A falling edge on `load_n_i` copies both input registers into both output registers in the same cycle.
- R5: While `load_n_i` is held low, the 16th falling `sclk_i` edge of a word updates both outputs, including the new code, with no load pulse.
- R6: A frame that ends with fewer than 16 falling `sclk_i` edges leaves both input registers unchanged.
- R7: Falling `sclk_i` edges after the 16th within one frame are ignored. The word is formed from the first 16 bits.
- R8: While `clr_n_i` is low, input and output registers of both channels are zero. The outputs read 0x000 with `twos_i`=0, or 0x800 (mid-scale) with `twos_i`=1. The cleared input registers stay zero through a later load.
- R9: With `twos_i`=1, each output equals its stored code with bit 11 inverted. With `twos_i`=0, it equals the stored code.
- R10: A `load_n_i` falling edge driven between two system clock edges shows on the outputs after the third following rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low reset |
| sclk_i | input | 1 | Serial clock; data taken on falling edges |
| sync_n_i | input | 1 | Active-low frame line; low opens a word |
| sdata_i | input | 1 | Serial data |
| load_n_i | input | 1 | Active-low load; falling edge updates, held low selects auto update |
| clr_n_i | input | 1 | Active-low clear of both channels |
| twos_i | input | 1 | Format select: 0 binary, 1 twos complement |
| code_a_o | output | 12 | Straight-binary code for DAC A |
| code_b_o | output | 12 | Straight-binary code for DAC B |

## Verification
A pin change needs two rising edges to cross the synchronizer. Load and clear then act on the third edge. A completed word adds one receiver register, so an auto update shows after the fourth edge. The format pin acts combinationally. The bench drives every pin at least four system clocks apart and samples on falling edges, at least six clocks after the last stimulus. For R10 it counts rising edges one by one and samples one time unit after each, before and after the expected edge.

// File: rtl/dac2_pkg.sv
package dac2_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_FULL  = 2'd2
    } rx_state_t;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/dac2_sync.sv
// Two-stage synchronizer for a vector of asynchronous pins.
module dac2_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[b];
                stab_q <= RST_VAL[b];
            end else begin
                meta_q <= async_i[b];
                stab_q <= meta_q;
            end
        end
        assign lvl_o[b] = stab_q;
    end

endmodule

// File: rtl/dac2_edge.sv
// Single-edge detector on a synchronized level; FALLING picks the polarity.
module dac2_edge #(
    parameter bit   FALLING = 1'b1,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic edge_o
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl_i;
    end

    if (FALLING) begin : g_fall
        assign edge_o = prev_q & ~lvl_i;
    end else begin : g_rise
        assign edge_o = ~prev_q & lvl_i;
    end

endmodule

// File: rtl/dac2_rx.sv
// Framed serial receiver: counts falling serial edges and emits one word.
module dac2_rx
    import dac2_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DATA_W = 12,
    parameter int CH_BIT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_lvl_i,
    input  logic              sclk_fall_i,
    input  logic              sdata_lvl_i,
    output rx_state_t         state_o,
    output logic              done_o,
    output logic              ch_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int CNT_W  = $clog2(WORD_W);
    localparam int CH_POS = WORD_W - 1 - CH_BIT;

    rx_state_t          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [DATA_W-2:0]  shreg_q;
    logic               ch_q;
    logic               last_bit;

    assign last_bit = sclk_fall_i && (cnt_q == CNT_W'(WORD_W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (!sync_lvl_i) state_d = RX_SHIFT;
            RX_SHIFT: begin
                if (sync_lvl_i)    state_d = RX_IDLE;
                else if (last_bit) state_d = RX_FULL;
            end
            RX_FULL:  if (sync_lvl_i) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            ch_q    <= 1'b0;
            done_o  <= 1'b0;
            ch_o    <= 1'b0;
            data_o  <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                RX_IDLE: cnt_q <= '0;
                RX_SHIFT: begin
                    if (!sync_lvl_i && sclk_fall_i) begin
                        cnt_q   <= cnt_q + 1'b1;
                        shreg_q <= {shreg_q[DATA_W-3:0], sdata_lvl_i};
                        if (cnt_q == CNT_W'(CH_POS)) ch_q <= sdata_lvl_i;
                        if (last_bit) begin
                            done_o <= 1'b1;
                            ch_o   <= ch_q;
                            data_o <= {shreg_q, sdata_lvl_i};
                        end
                    end
                end
                RX_FULL: cnt_q <= '0;
                default: cnt_q <= '0;
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/dac2_regs.sv
// Input and output register pairs per channel, with clear and format mapping.
module dac2_regs
    import dac2_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_lvl_i,
    input  logic              load_lvl_i,
    input  logic              load_fall_i,
    input  logic              done_i,
    input  logic              ch_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              twos_i,
    output logic [DATA_W-1:0] code_o [NUM_CH]
);

    localparam logic [DATA_W-1:0] MSB_ONE = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] in_q  [NUM_CH];
    logic [DATA_W-1:0] out_q [NUM_CH];
    logic [DATA_W-1:0] in_d  [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign in_d[c] = (done_i && (ch_i == c[0])) ? data_i : in_q[c];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                in_q[c]  <= '0;
                out_q[c] <= '0;
            end else if (!clr_lvl_i) begin
                in_q[c]  <= '0;
                out_q[c] <= '0;
            end else begin
                in_q[c] <= in_d[c];
                if (done_i && !load_lvl_i) out_q[c] <= in_d[c];
                else if (load_fall_i)      out_q[c] <= in_q[c];
            end
        end

        assign code_o[c] = out_q[c] ^ (twos_i ? MSB_ONE : '0);
    end

endmodule

// File: rtl/dac2_serial_front.sv
module dac2_serial_front
    import dac2_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DATA_W = 12,
    parameter int CH_BIT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sync_n_i,
    input  logic              sdata_i,
    input  logic              load_n_i,
    input  logic              clr_n_i,
    input  logic              twos_i,
    output logic [DATA_W-1:0] code_a_o,
    output logic [DATA_W-1:0] code_b_o
);

    localparam int NPIN = 5;
    localparam logic [NPIN-1:0] PIN_RST = 5'b01111;

    logic [NPIN-1:0]   pin_lvl;
    logic              sclk_lvl, sync_lvl, load_lvl, clr_lvl, sdata_lvl;
    logic              sclk_fall, load_fall, sync_rise;
    rx_state_t         rx_state;
    logic              word_done, word_ch;
    logic [DATA_W-1:0] word_data;
    logic [DATA_W-1:0] code [NUM_CH];

    dac2_sync #(.W(NPIN), .RST_VAL(PIN_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdata_i, clr_n_i, load_n_i, sync_n_i, sclk_i}),
        .lvl_o   (pin_lvl)
    );

    assign {sdata_lvl, clr_lvl, load_lvl, sync_lvl, sclk_lvl} = pin_lvl;

    dac2_edge #(.FALLING(1'b1), .RST_VAL(1'b1)) u_sclk_edge (
        .clk (clk), .rst_n (rst_n), .lvl_i (sclk_lvl), .edge_o (sclk_fall)
    );

    dac2_edge #(.FALLING(1'b1), .RST_VAL(1'b1)) u_load_edge (
        .clk (clk), .rst_n (rst_n), .lvl_i (load_lvl), .edge_o (load_fall)
    );

    dac2_edge #(.FALLING(1'b0), .RST_VAL(1'b1)) u_sync_edge (
        .clk (clk), .rst_n (rst_n), .lvl_i (sync_lvl), .edge_o (sync_rise)
    );

    dac2_rx #(.WORD_W(WORD_W), .DATA_W(DATA_W), .CH_BIT(CH_BIT)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_lvl_i  (sync_lvl),
        .sclk_fall_i (sclk_fall),
        .sdata_lvl_i (sdata_lvl),
        .state_o     (rx_state),
        .done_o      (word_done),
        .ch_o        (word_ch),
        .data_o      (word_data)
    );

    dac2_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_lvl_i   (clr_lvl),
        .load_lvl_i  (load_lvl),
        .load_fall_i (load_fall),
        .done_i      (word_done),
        .ch_i        (word_ch),
        .data_i      (word_data),
        .twos_i      (twos_i),
        .code_o      (code)
    );

    assign code_a_o = code[0];
    assign code_b_o = code[1];

endmodule

// File: rtl/dac2_serial_front_chk.sv
module dac2_serial_front_chk
    import dac2_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              twos_i,
    input logic [DATA_W-1:0] code_a_o,
    input logic [DATA_W-1:0] code_b_o,
    input logic              clr_lvl,
    input logic              load_lvl,
    input logic              sync_rise,
    input rx_state_t         rx_state,
    input logic              word_done,
    input logic              word_ch,
    input logic [DATA_W-1:0] word_data
);

    localparam logic [DATA_W-1:0] MSB_ONE = {1'b1, {(DATA_W-1){1'b0}}};

    // R2: one completed word gives a single-cycle pulse
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done);

    // R3: no update while load is high and no clear
    a_r3_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_lvl && load_lvl) |=> ($stable(code_a_o) || !$stable(twos_i)));
    a_r3_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_lvl && load_lvl) |=> ($stable(code_b_o) || !$stable(twos_i)));

    // R5: auto update carries the new word to its channel
    a_r5_auto_a: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !load_lvl && clr_lvl && !word_ch)
        |=> ((code_a_o ^ (twos_i ? MSB_ONE : '0)) == $past(word_data)));
    a_r5_auto_b: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !load_lvl && clr_lvl && word_ch)
        |=> ((code_b_o ^ (twos_i ? MSB_ONE : '0)) == $past(word_data)));

    // R6: aborted frame never completes a word
    a_r6_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state == RX_SHIFT && sync_rise) |=> !word_done);

    // R8: clear drives both outputs to the zero code
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_lvl |=> (((code_a_o | code_b_o) ^ (twos_i ? MSB_ONE : '0)) == '0));

endmodule

bind dac2_serial_front dac2_serial_front_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .twos_i    (twos_i),
    .code_a_o  (code_a_o),
    .code_b_o  (code_b_o),
    .clr_lvl   (clr_lvl),
    .load_lvl  (load_lvl),
    .sync_rise (sync_rise),
    .rx_state  (rx_state),
    .word_done (word_done),
    .word_ch   (word_ch),
    .word_data (word_data)
);

// File: tb/dac2_serial_front_tb.sv
`timescale 1ns/1ps
module dac2_serial_front_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1, sync_n = 1'b1, sdata = 1'b0;
    logic        load_n = 1'b1, clr_n = 1'b1, twos = 1'b0;
    logic [11:0] code_a, code_b;

    int          n_checks = 0;
    int          n_errors = 0;
    bit          done_flag = 1'b0;
    logic [11:0] exp_in  [2];
    logic [11:0] exp_out [2];

    always #5 clk = ~clk;

    dac2_serial_front dut_i (
        .clk (clk), .rst_n (rst_n), .sclk_i (sclk), .sync_n_i (sync_n),
        .sdata_i (sdata), .load_n_i (load_n), .clr_n_i (clr_n),
        .twos_i (twos), .code_a_o (code_a), .code_b_o (code_b)
    );

    function automatic logic [11:0] fmt(input logic [11:0] v);
        return twos ? (v ^ 12'h800) : v;
    endfunction

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%03h expected=%03h", req, act, exp);
        end
    endtask

    task automatic chk_both(input string req);
        chk(req, code_a, fmt(exp_out[0]));
        chk(req, code_b, fmt(exp_out[1]));
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // frame with nfall falling serial edges; bits past 16 are filler
    task automatic send(input logic [15:0] w, input int nfall);
        sync_n = 1'b0;
        wait_n(4);
        for (int i = 0; i < nfall; i++) begin
            sclk  = 1'b1;
            sdata = (i < 16) ? w[15-i] : i[0];
            wait_n(4);
            sclk = 1'b0;
            wait_n(4);
        end
        sclk = 1'b1;
        wait_n(4);
        sync_n = 1'b1;
        wait_n(8);
        if (nfall >= 16) begin
            exp_in[w[13]] = w[11:0];
            if (!load_n) exp_out = exp_in;
        end
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        wait_n(6);
        load_n = 1'b1;
        wait_n(6);
        exp_out = exp_in;
    endtask

    task automatic do_clear();
        clr_n = 1'b0;
        wait_n(6);
        exp_in  = '{12'h000, 12'h000};
        exp_out = '{12'h000, 12'h000};
        chk_both("R8 during clear");
        clr_n = 1'b1;
        wait_n(6);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        exp_in  = '{12'h000, 12'h000};
        exp_out = '{12'h000, 12'h000};
        wait_n(3);
        chk_both("R1 in reset");
        wait_n(2);
        rst_n = 1'b1;
        wait_n(2);
        chk_both("R1 after reset");
        twos = 1'b1;
        wait_n(1);
        chk_both("R1 twos mid-scale");
        twos = 1'b0;
        wait_n(1);

        // R10: load latency, counted edge by edge
        send(16'h05A3, 16);
        chk_both("R3 word without load");
        load_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 chk("R10 not yet after 2 edges", code_a, 12'h000);
        @(posedge clk);
        #1 chk("R10 updated after 3 edges", code_a, 12'h5A3);
        wait_n(4);
        load_n = 1'b1;
        wait_n(6);
        exp_out = exp_in;

        // R2 R3 R4 R9: sweep of format, channel and code
        for (int tw = 0; tw < 2; tw++) begin
            twos = tw[0];
            for (int ch = 0; ch < 2; ch++) begin
                for (int k = 0; k < 16; k++) begin
                    logic [11:0] code;
                    logic [3:0]  kb;
                    code = 12'(k * 273);
                    kb   = k[3:0];
                    send({kb[0], kb[1], ch[0], kb[2], code}, 16);
                    chk(ch[0] ? "R3 B hold" : "R3 A hold",
                        ch[0] ? code_b : code_a, fmt(exp_out[ch]));
                    pulse_load();
                    chk_both("R2 R4 R9 after load");
                end
            end
        end
        twos = 1'b0;
        wait_n(2);

        // R5: auto update with load held low
        load_n = 1'b0;
        wait_n(6);
        exp_out = exp_in;
        for (int k = 0; k < 12; k++) begin
            send({2'b00, k[0], 1'b0, 12'(12'hFFF - k * 331)}, 16);
            chk_both("R5 auto update");
        end
        load_n = 1'b1;
        wait_n(6);

        // R6: short frames discarded
        send(16'h0ABC, 10);
        pulse_load();
        chk_both("R6 10-edge frame");
        send(16'h2123, 15);
        pulse_load();
        chk_both("R6 15-edge frame");

        // R7: extra edges ignored
        send(16'h2E71, 21);
        pulse_load();
        chk_both("R7 extra edges");

        // R8: clear in both formats, input stage cleared too
        send(16'h0777, 16);
        do_clear();
        chk_both("R8 after clear");
        pulse_load();
        chk_both("R8 inputs cleared");
        send(16'h2456, 16);
        pulse_load();
        twos = 1'b1;
        do_clear();
        chk_both("R8 twos clear mid-scale");
        chk("R8 twos value", code_b, 12'h800);
        twos = 1'b0;
        wait_n(2);

        finish_run();
    end

endmodule